// File: doc/BRIEF.md
# Floating-Point Status Word with Compare Queue

This block keeps the 32-bit status word that sits beside a floating-point arithmetic unit. The arithmetic unit reads the current rounding direction and the denormal-flush setting from decoded outputs. After each operation it reports the exceptions that the operation raised, and the block folds them into sticky flag bits. If a raised exception has its enable bit set, the block also requests an assist trap for one cycle.

A compare is reported with a two-bit relation code, a five-bit condition-select mask and a target index. The mask bit chosen by the relation becomes the compare outcome. A nonzero index sends the outcome to one indexed condition bit. A zero index shifts the ten-entry condition history down by one place, moves the previous primary condition bit into the top of that history, and then stores the outcome in the primary condition bit. Software can overwrite the whole word at any time.

Top module: `fp_status_word`

## Requirements
- R1: While `rst` is high at a clock edge, the status word is cleared to zero and `assist_trap` is low in the following cycle.
- R2: A software write (`sw_we` high) loads `sw_wdata` into the whole word at the next edge, clears the trap output, and overrides any operation or compare strobe in the same cycle.
- R3: `round_mode` follows word bits 10:9 (0 nearest-even, 1 toward zero, 2 toward plus infinity, 3 toward minus infinity), and `flush_zero` follows word bit 5.
- R4: On `op_done`, flag vector bit i (0 inexact, 1 underflow, 2 overflow, 3 divide-by-zero, 4 invalid) is ORed into word bit 27+i. The flag bits are sticky. A zero vector leaves the word unchanged.
- R5: `assist_trap` is high in the cycle after an `op_done` or `cmp_valid` strobe exactly when the reported flags ANDed with word bits 4:0 (the enables) are nonzero. Otherwise it is low.
- R6: The compare outcome is a mask bit selected by `cmp_rel`: code 0 (greater) picks mask bit 4, code 1 (less) picks bit 3, code 2 (equal) picks bit 2, and code 3 (unordered) picks bit 1.
- R7: A compare with index y in 1..7 writes the outcome to word bit 22−y and changes no other condition bit.
- R8: A compare with index 0 moves bits 21:12 into 20:11, copies bit 26 into bit 21, and writes the outcome into bit 26.
- R9: A compare folds the `op_flags` it carries into the sticky bits and can raise the trap, in addition to its condition update.
- R10: In a cycle with no write, no operation strobe and no compare strobe, the word does not change. Flags presented without a strobe are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 32 | Word value written by software |
| op_done | input | 1 | Arithmetic operation finished |
| op_flags | input | 5 | Exceptions raised by the operation or compare |
| cmp_valid | input | 1 | Compare result strobe |
| cmp_rel | input | 2 | Relation code: 0 greater, 1 less, 2 equal, 3 unordered |
| cmp_mask | input | 5 | Condition-select mask |
| cmp_idx | input | 3 | Target index; 0 selects the queue |
| status_word | output | 32 | Current status word |
| round_mode | output | 2 | Decoded rounding direction |
| flush_zero | output | 1 | Denormal flush enable |
| assist_trap | output | 1 | One-cycle assist-trap request |

## Verification
The assertions assume that reset is held for at least one edge before the first strobe. They also assume that a software write carries its full word, because the checks relate the next word to the previous one and to the written data. The stimulus drives `sw_wdata` and the strobes only on falling edges. It mixes concurrent write/operation cycles, flags left on without a strobe, and compares with a zero index and with every nonzero index, so every transition the properties describe happens under these conditions.

// File: rtl/fpsw_pkg.sv
package fpsw_pkg;
    localparam int WORD_W     = 32;
    localparam int FLAG_W     = 5;
    localparam int FLAG_LSB   = 27;
    localparam int ENABLE_LSB = 0;
    localparam int RND_LSB    = 9;
    localparam int FLUSH_BIT  = 5;
    localparam int CMP_BIT    = 26;
    localparam int QUEUE_TOP  = 21;
    localparam int QUEUE_LEN  = 10;
    localparam int QUEUE_BASE = QUEUE_TOP - QUEUE_LEN;
    localparam int IDX_W      = 3;

    typedef enum logic [1:0] {
        RND_NEAREST = 2'd0,
        RND_ZERO    = 2'd1,
        RND_POS_INF = 2'd2,
        RND_NEG_INF = 2'd3
    } round_e;

    typedef enum logic [1:0] {
        REL_GT = 2'd0,
        REL_LT = 2'd1,
        REL_EQ = 2'd2,
        REL_UN = 2'd3
    } relation_e;

    typedef struct packed {
        logic              valid;
        relation_e         rel;
        logic [FLAG_W-1:0] mask;
        logic [IDX_W-1:0]  idx;
    } cmp_req_t;

    function automatic logic select_cond(relation_e rel, logic [FLAG_W-1:0] mask);
        logic r;
        case (rel)
            REL_GT:  r = mask[4];
            REL_LT:  r = mask[3];
            REL_EQ:  r = mask[2];
            default: r = mask[1];
        endcase
        return r;
    endfunction
endpackage

// File: rtl/fpsw_flag_fold.sv
module fpsw_flag_fold
    import fpsw_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    input  logic              apply_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic [WORD_W-1:0] word_o,
    output logic              trap_o
);
    logic [FLAG_W-1:0] hit;

    assign hit = flags_i & word_i[ENABLE_LSB +: FLAG_W];

    always_comb begin
        word_o = word_i;
        if (apply_i) begin
            word_o[FLAG_LSB +: FLAG_W] = word_i[FLAG_LSB +: FLAG_W] | flags_i;
        end
    end

    assign trap_o = apply_i && (hit != '0);
endmodule

// File: rtl/fpsw_cmp_update.sv
module fpsw_cmp_update
    import fpsw_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    input  cmp_req_t          req_i,
    output logic [WORD_W-1:0] word_o
);
    logic                 outcome;
    logic [QUEUE_LEN-1:0] shifted;

    assign outcome = select_cond(req_i.rel, req_i.mask);

    genvar g;
    generate
        for (g = 0; g < QUEUE_LEN; g++) begin : g_shift
            assign shifted[g] = word_i[QUEUE_BASE + g + 1];
        end
    endgenerate

    always_comb begin
        word_o = word_i;
        if (req_i.valid) begin
            if (req_i.idx != '0) begin
                word_o[QUEUE_TOP + 1 - int'(req_i.idx)] = outcome;
            end else begin
                word_o[QUEUE_BASE +: QUEUE_LEN] = shifted;
                word_o[QUEUE_TOP]               = word_i[CMP_BIT];
                word_o[CMP_BIT]                 = outcome;
            end
        end
    end
endmodule

// File: rtl/fpsw_ctrl_decode.sv
module fpsw_ctrl_decode
    import fpsw_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output round_e            rnd_o,
    output logic              flush_o
);
    assign rnd_o   = round_e'(word_i[RND_LSB +: 2]);
    assign flush_o = word_i[FLUSH_BIT];
endmodule

// File: rtl/fp_status_word.sv
module fp_status_word
    import fpsw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_we,
    input  logic [WORD_W-1:0] sw_wdata,
    input  logic              op_done,
    input  logic [FLAG_W-1:0] op_flags,
    input  logic              cmp_valid,
    input  logic [1:0]        cmp_rel,
    input  logic [FLAG_W-1:0] cmp_mask,
    input  logic [IDX_W-1:0]  cmp_idx,
    output logic [WORD_W-1:0] status_word,
    output logic [1:0]        round_mode,
    output logic              flush_zero,
    output logic              assist_trap
);
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] folded;
    logic [WORD_W-1:0] updated;
    logic              trap_q;
    logic              fold_trap;
    cmp_req_t          req;
    round_e            rnd;

    assign req.valid = cmp_valid;
    assign req.rel   = relation_e'(cmp_rel);
    assign req.mask  = cmp_mask;
    assign req.idx   = cmp_idx;

    fpsw_flag_fold u_fold (
        .word_i  (word_q),
        .apply_i (op_done | cmp_valid),
        .flags_i (op_flags),
        .word_o  (folded),
        .trap_o  (fold_trap)
    );

    fpsw_cmp_update u_cmp (
        .word_i (folded),
        .req_i  (req),
        .word_o (updated)
    );

    fpsw_ctrl_decode u_dec (
        .word_i  (word_q),
        .rnd_o   (rnd),
        .flush_o (flush_zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            trap_q <= 1'b0;
        end else if (sw_we) begin
            word_q <= sw_wdata;
            trap_q <= 1'b0;
        end else begin
            word_q <= updated;
            trap_q <= fold_trap;
        end
    end

    assign status_word = word_q;
    assign round_mode  = rnd;
    assign assist_trap = trap_q;

    a_r2_sw_load: assert property (@(posedge clk) disable iff (rst)
        sw_we |=> (status_word == $past(sw_wdata)) && !assist_trap);

    a_r4_sticky_flags: assert property (@(posedge clk) disable iff (rst)
        !sw_we |=> ((status_word[31:27] & $past(status_word[31:27])) == $past(status_word[31:27])));

    a_r5_trap_needs_strobe: assert property (@(posedge clk) disable iff (rst)
        (sw_we || !(op_done || cmp_valid)) |=> !assist_trap);

    a_r5_enables_hold: assert property (@(posedge clk) disable iff (rst)
        !sw_we |=> $stable(status_word[4:0]));

    a_r7_target_spares_queue: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && !sw_we && cmp_idx != '0) |=> $stable(status_word[26:22]) && $stable(status_word[14:11]));

    a_r8_queue_shift: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && !sw_we && cmp_idx == '0) |=> (status_word[20:11] == $past(status_word[21:12]))
                                                  && (status_word[21] == $past(status_word[26])));

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!sw_we && !op_done && !cmp_valid) |=> $stable(status_word));
endmodule

// File: tb/sim_fp_status_word.sv
`timescale 1ns/1ps
module sim_fp_status_word;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sw_we = 1'b0;
    logic [31:0] sw_wdata = '0;
    logic        op_done = 1'b0;
    logic [4:0]  op_flags = '0;
    logic        cmp_valid = 1'b0;
    logic [1:0]  cmp_rel = '0;
    logic [4:0]  cmp_mask = '0;
    logic [2:0]  cmp_idx = '0;
    logic [31:0] status_word;
    logic [1:0]  round_mode;
    logic        flush_zero;
    logic        assist_trap;

    int checks = 0;
    int errors = 0;
    logic [31:0] m_word = '0;
    logic        m_trap = 1'b0;
    bit          done = 0;

    always #2 clk = ~clk;

    fp_status_word u0 (
        .clk(clk), .rst(rst), .sw_we(sw_we), .sw_wdata(sw_wdata),
        .op_done(op_done), .op_flags(op_flags), .cmp_valid(cmp_valid),
        .cmp_rel(cmp_rel), .cmp_mask(cmp_mask), .cmp_idx(cmp_idx),
        .status_word(status_word), .round_mode(round_mode),
        .flush_zero(flush_zero), .assist_trap(assist_trap)
    );

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model_edge();
        logic c;
        if (rst) begin
            m_word = '0; m_trap = 0;
        end else if (sw_we) begin
            m_word = sw_wdata; m_trap = 0;
        end else begin
            m_trap = 0;
            if (op_done || cmp_valid) begin
                for (int i = 0; i < 5; i++) if (op_flags[i]) m_word[27+i] = 1'b1;
                m_trap = (op_flags & m_word[4:0]) != 0;
            end
            if (cmp_valid) begin
                c = cmp_mask[4 - cmp_rel];
                if (cmp_idx != 0) m_word[22 - cmp_idx] = c;
                else begin
                    for (int k = 11; k <= 20; k++) m_word[k] = m_word[k+1];
                    m_word[21] = m_word[26];
                    m_word[26] = c;
                end
            end
        end
    endtask

    task automatic step(string tag, bit we, logic [31:0] wd, bit op, logic [4:0] fl,
                        bit cv, logic [1:0] rel, logic [4:0] mask, logic [2:0] idx);
        sw_we = we; sw_wdata = wd; op_done = op; op_flags = fl;
        cmp_valid = cv; cmp_rel = rel; cmp_mask = mask; cmp_idx = idx;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(tag, "word", status_word, m_word);
        check(tag, "round", {30'd0, round_mode}, {30'd0, m_word[10:9]});
        check(tag, "flush", {31'd0, flush_zero}, {31'd0, m_word[5]});
        check(tag, "trap", {31'd0, assist_trap}, {31'd0, m_trap});
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step("R1", 1, 32'hFFFF_FFFF, 1, 5'h1F, 0, 0, 0, 0);
        rst = 1'b0;
        // R3: each rounding code and flush bit
        step("R3", 1, 32'h0000_0000, 0, 0, 0, 0, 0, 0);
        step("R3", 1, 32'h0000_0200, 0, 0, 0, 0, 0, 0);
        step("R3", 1, 32'h0000_0400, 0, 0, 0, 0, 0, 0);
        step("R3", 1, 32'h0000_0620, 0, 0, 0, 0, 0, 0);
        // R4: folding, stickiness, zero vector
        step("R4", 0, 0, 1, 5'b00101, 0, 0, 0, 0);
        step("R4", 0, 0, 1, 5'b00000, 0, 0, 0, 0);
        step("R4", 0, 0, 1, 5'b10010, 0, 0, 0, 0);
        step("R4", 0, 0, 1, 5'b00001, 0, 0, 0, 0);
        // R10: flags without strobe ignored
        step("R10", 0, 0, 0, 5'b01000, 0, 2'd1, 5'h1F, 0);
        // R5: enables and trap
        step("R5", 1, 32'h0000_0008, 0, 0, 0, 0, 0, 0);
        step("R5", 0, 0, 1, 5'b01000, 0, 0, 0, 0);
        step("R5", 0, 0, 1, 5'b00001, 0, 0, 0, 0);
        step("R5", 0, 0, 0, 5'b01000, 0, 0, 0, 0);
        // R2: write overrides op and compare
        step("R2", 1, 32'h0000_001F, 1, 5'h1F, 1, 0, 5'h1F, 0);
        step("R2", 1, 32'h0000_0000, 0, 0, 0, 0, 0, 0);
        // R6/R7: every relation against every index
        for (int r = 0; r < 4; r++) begin
            for (int y = 1; y < 8; y++) begin
                step("R7", 0, 0, 0, 0, 1, 2'(r), 5'b11110, 3'(y));
                step("R6", 0, 0, 0, 0, 1, 2'(r), 5'(1 << (4 - r)), 3'(y));
                step("R6", 0, 0, 0, 0, 1, 2'(r), 5'(~(1 << (4 - r))), 3'(y));
            end
        end
        // R8: queue shifting with alternating outcomes
        step("R8", 1, 32'h0420_0000, 0, 0, 0, 0, 0, 0);
        for (int n = 0; n < 14; n++) begin
            step("R8", 0, 0, 0, 0, 1, 2'(n % 4), (n % 3 == 0) ? 5'b11110 : 5'b00000, 3'd0);
        end
        step("R8", 1, 32'h003F_F800, 0, 0, 0, 0, 0, 0);
        step("R8", 0, 0, 0, 0, 1, 2'd3, 5'b00000, 3'd0);
        step("R8", 0, 0, 0, 0, 1, 2'd2, 5'b00100, 3'd0);
        // R9: compare carrying flags, with and without trap
        step("R9", 1, 32'h0000_0010, 0, 0, 0, 0, 0, 0);
        step("R9", 0, 0, 0, 5'b10000, 1, 2'd0, 5'b10000, 3'd0);
        step("R9", 0, 0, 0, 5'b00100, 1, 2'd1, 5'b01000, 3'd4);
        step("R9", 0, 0, 1, 5'b00010, 1, 2'd3, 5'b00010, 3'd1);
        // R10: idle cycles
        step("R10", 0, 0, 0, 5'h1F, 0, 0, 0, 0);
        step("R10", 0, 0, 0, 0, 0, 0, 0, 0);
        // R1: reset again clears everything
        rst = 1'b1;
        step("R1", 0, 0, 1, 5'h1F, 0, 0, 0, 0);
        rst = 1'b0;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule